// File: doc/BRIEF.md
# Recursive Radix-4 Twiddle Generator

This block feeds one radix-4 butterfly. For each angle index k it returns the three non-trivial twiddle factors W^k, W^2k and W^3k, with W = exp(-j·2π/N). All three arrive in the same cycle, together with the trivial factor W^0 = 1. Only the first stage holds trigonometric tables. It splits k into a coarse part and a fine part, reads one small table for each part, and combines the two entries with a complex product using four multipliers. The second stage derives the double angle from the first result with two multipliers. The third stage derives the triple angle from the first and second results with two more multipliers. Delay lines bring the earlier results and the valid flag into step with the last stage.

All values are two's complement with two integer bits and FB = DW-2 fraction bits, so ONE = 2^FB is exact. The real part of each output is cos(m·θ) and the imaginary part is -sin(m·θ), where θ = 2πk/N and m is 1, 2 or 3. A new index can be accepted every clock, and a full set of results leaves the block every clock.

Top module: `twr4_recursive_gen`

## Requirements
- R1: The k input is split in two. The coarse index ci is the upper LOG2N-FINE_BITS bits and the fine index fi is the lower FINE_BITS bits. Define cc = T(cos, ci·2^FINE_BITS), cs = T(-sin, ci·2^FINE_BITS), fc = T(cos, fi) and fs = T(-sin, fi), where T(f, j) = floor(f(2πj/N)·ONE + 0.5). Then w1_re = rnd(cc·fc - cs·fs) and w1_im = rnd(cs·fc + cc·fs).
- R2: w2_re = rnd(2·w1_re·w1_re - ONE·ONE) and w2_im = rnd(2·w1_im·w1_re). Both use the w1 values of the same k.
- R3: w3_re = rnd(2·w1_re·w2_re - w1_re·ONE) and w3_im = rnd(2·w1_re·w2_im - w1_im·ONE). Both use the w1 and w2 values of the same k.
- R4: rnd(x) adds 2^(FB-1) to the full-precision value and then shifts arithmetically right by FB. The doubling is applied before rnd. The result saturates to the signed DW-bit range.
- R5: out_valid is high exactly 7 clocks after in_valid was sampled high. w1, w2 and w3 in that cycle all belong to the k sampled with it.
- R6: Indices presented on consecutive clocks produce results on consecutive clocks, with no bubbles.
- R7: w0_re always equals ONE and w0_im always equals 0.
- R8: While rst_n is low, out_valid and all w1 to w3 outputs are 0. A reset applied while results are in flight discards them, so out_valid stays low until a new input has had 7 clocks to pass through.
- R9: Each w1, w2 and w3 component is within 8 LSB of the exact cos(m·θ)·ONE or -sin(m·θ)·ONE.
- R10: A cycle with in_valid low produces out_valid low 7 clocks later, even when it sits between valid cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Angle index present |
| in_k | input | LOG2N | Angle index k |
| out_valid | output | 1 | Twiddle set present |
| w0_re | output | DW | Trivial twiddle, real part (ONE) |
| w0_im | output | DW | Trivial twiddle, imaginary part (0) |
| w1_re | output | DW | cos θ |
| w1_im | output | DW | -sin θ |
| w2_re | output | DW | cos 2θ |
| w2_im | output | DW | -sin 2θ |
| w3_re | output | DW | cos 3θ |
| w3_im | output | DW | -sin 3θ |

## Verification
In every busy cycle the block does two things at once: it accepts a new index and it delivers the result for an index taken seven cycles earlier. A back-to-back sweep over all N indices exercises this overlap, and a queue model pairs each output set with its own index, so any skew between the three aligned paths shows up as a mismatch. Gapped and pseudo-random valid patterns check that bubbles keep their place. A reset asserted with results still in flight is checked to clear out_valid before the next accepted index.

// File: rtl/twr4_pkg.sv
package twr4_pkg;

    // Round half up at bit fb, then clamp to a signed dw-bit range.
    function automatic longint rnd_shift(input longint x, input int fb);
        return (x + (longint'(1) <<< (fb - 1))) >>> fb;
    endfunction

    function automatic longint clamp_dw(input longint x, input int dw);
        longint hi;
        longint lo;
        hi = (longint'(1) <<< (dw - 1)) - 1;
        lo = -(longint'(1) <<< (dw - 1));
        if (x > hi)      return hi;
        else if (x < lo) return lo;
        else             return x;
    endfunction

    function automatic longint rnd_sat(input longint x, input int fb, input int dw);
        return clamp_dw(rnd_shift(x, fb), dw);
    endfunction

endpackage

// File: rtl/twr4_delay.sv
module twr4_delay #(
    parameter int W     = 1,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (DEPTH == 0) begin : g_wire
            assign q = d;
        end else begin : g_pipe
            logic [W-1:0] sr [DEPTH];
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) sr[i] <= '0;
                end else begin
                    sr[0] <= d;
                    for (int i = 1; i < DEPTH; i++) sr[i] <= sr[i-1];
                end
            end
            assign q = sr[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/twr4_base_stage.sv
module twr4_base_stage
    import twr4_pkg::*;
#(
    parameter int DW        = 16,
    parameter int LOG2N     = 8,
    parameter int FINE_BITS = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LOG2N-1:0]        k,
    output logic signed [DW-1:0]    c_out,
    output logic signed [DW-1:0]    s_out
);
    localparam int  FB     = DW - 2;
    localparam int  CB     = LOG2N - FINE_BITS;
    localparam int  NC     = 1 << CB;
    localparam int  NF     = 1 << FINE_BITS;
    localparam int  PW     = 2 * DW;
    localparam real SCALE  = real'(1 << FB);
    localparam real TWO_PI = 6.283185307179586;

    // Coarse table: angles stepping by NF indices.
    function automatic logic [NC*DW-1:0] build_coarse(input bit want_sin);
        logic [NC*DW-1:0] v;
        real th;
        real x;
        v = '0;
        for (int i = 0; i < NC; i++) begin
            th = TWO_PI * real'(i * NF) / real'(1 << LOG2N);
            x  = want_sin ? -$sin(th) : $cos(th);
            v[i*DW +: DW] = DW'($rtoi($floor(x * SCALE + 0.5)));
        end
        return v;
    endfunction

    // Fine table: angles stepping by one index.
    function automatic logic [NF*DW-1:0] build_fine(input bit want_sin);
        logic [NF*DW-1:0] v;
        real th;
        real x;
        v = '0;
        for (int i = 0; i < NF; i++) begin
            th = TWO_PI * real'(i) / real'(1 << LOG2N);
            x  = want_sin ? -$sin(th) : $cos(th);
            v[i*DW +: DW] = DW'($rtoi($floor(x * SCALE + 0.5)));
        end
        return v;
    endfunction

    localparam logic [NC*DW-1:0] CRS_COS = build_coarse(1'b0);
    localparam logic [NC*DW-1:0] CRS_SIN = build_coarse(1'b1);
    localparam logic [NF*DW-1:0] FIN_COS = build_fine(1'b0);
    localparam logic [NF*DW-1:0] FIN_SIN = build_fine(1'b1);

    logic [CB-1:0]        ci;
    logic [FINE_BITS-1:0] fi;
    assign ci = k[LOG2N-1:FINE_BITS];
    assign fi = k[FINE_BITS-1:0];

    logic signed [DW-1:0] cc_q, cs_q, fc_q, fs_q;
    logic signed [PW-1:0] p_rr, p_ii, p_ri, p_ir;

    // Cycle 1: table reads; cycle 2: products; cycle 3: sum, round.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cc_q  <= '0;
            cs_q  <= '0;
            fc_q  <= '0;
            fs_q  <= '0;
            p_rr  <= '0;
            p_ii  <= '0;
            p_ri  <= '0;
            p_ir  <= '0;
            c_out <= '0;
            s_out <= '0;
        end else begin
            cc_q  <= CRS_COS[ci*DW +: DW];
            cs_q  <= CRS_SIN[ci*DW +: DW];
            fc_q  <= FIN_COS[fi*DW +: DW];
            fs_q  <= FIN_SIN[fi*DW +: DW];
            p_rr  <= PW'(cc_q) * PW'(fc_q);
            p_ii  <= PW'(cs_q) * PW'(fs_q);
            p_ri  <= PW'(cs_q) * PW'(fc_q);
            p_ir  <= PW'(cc_q) * PW'(fs_q);
            c_out <= DW'(rnd_sat(longint'(p_rr) - longint'(p_ii), FB, DW));
            s_out <= DW'(rnd_sat(longint'(p_ri) + longint'(p_ir), FB, DW));
        end
    end

    // R4: the rotated base value never needs clamping.
    logic signed [63:0] pre_c;
    assign pre_c = rnd_shift(longint'(p_rr) - longint'(p_ii), FB);
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_c <= ((64'sd1 <<< (DW-1)) - 1)) && (pre_c >= -(64'sd1 <<< (DW-1))));
endmodule

// File: rtl/twr4_double_stage.sv
module twr4_double_stage
    import twr4_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] c_in,
    input  logic signed [DW-1:0] s_in,
    output logic signed [DW-1:0] c2_out,
    output logic signed [DW-1:0] s2_out
);
    localparam int     FB     = DW - 2;
    localparam int     PW     = 2 * DW;
    localparam longint ONE_SQ = longint'(1) <<< (2 * FB);

    logic signed [PW-1:0] p_cc, p_sc;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_cc   <= '0;
            p_sc   <= '0;
            c2_out <= '0;
            s2_out <= '0;
        end else begin
            p_cc   <= PW'(c_in) * PW'(c_in);
            p_sc   <= PW'(s_in) * PW'(c_in);
            c2_out <= DW'(rnd_sat((longint'(p_cc) <<< 1) - ONE_SQ, FB, DW));
            s2_out <= DW'(rnd_sat(longint'(p_sc) <<< 1, FB, DW));
        end
    end

    logic signed [63:0] pre_c2;
    assign pre_c2 = rnd_shift((longint'(p_cc) <<< 1) - ONE_SQ, FB);
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_c2 <= ((64'sd1 <<< (DW-1)) - 1)) && (pre_c2 >= -(64'sd1 <<< (DW-1))));

    // R2: a zero sine yields a zero double-angle sine two cycles later.
    assert_zero_sine_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_in == '0) |-> ##2 (s2_out == '0));
endmodule

// File: rtl/twr4_triple_stage.sv
module twr4_triple_stage
    import twr4_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] c_in,
    input  logic signed [DW-1:0] s_in,
    input  logic signed [DW-1:0] c2_in,
    input  logic signed [DW-1:0] s2_in,
    output logic signed [DW-1:0] c3_out,
    output logic signed [DW-1:0] s3_out
);
    localparam int FB = DW - 2;
    localparam int PW = 2 * DW;

    logic signed [PW-1:0] p_a, p_b;
    logic signed [DW-1:0] c_d, s_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_a    <= '0;
            p_b    <= '0;
            c_d    <= '0;
            s_d    <= '0;
            c3_out <= '0;
            s3_out <= '0;
        end else begin
            p_a    <= PW'(c_in) * PW'(c2_in);
            p_b    <= PW'(c_in) * PW'(s2_in);
            c_d    <= c_in;
            s_d    <= s_in;
            c3_out <= DW'(rnd_sat((longint'(p_a) <<< 1) - (longint'(c_d) <<< FB), FB, DW));
            s3_out <= DW'(rnd_sat((longint'(p_b) <<< 1) - (longint'(s_d) <<< FB), FB, DW));
        end
    end

    logic signed [63:0] pre_c3;
    assign pre_c3 = rnd_shift((longint'(p_a) <<< 1) - (longint'(c_d) <<< FB), FB);
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_c3 <= ((64'sd1 <<< (DW-1)) - 1)) && (pre_c3 >= -(64'sd1 <<< (DW-1))));

    // R3: with zero cosine the triple cosine is zero and the triple sine is the negated sine.
    assert_zero_cos_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (c_in == '0) |-> ##2 ((c3_out == '0) && ((s3_out + $past(s_in, 2)) == '0)));
endmodule

// File: rtl/twr4_recursive_gen.sv
module twr4_recursive_gen #(
    parameter int DW        = 16,
    parameter int LOG2N     = 8,
    parameter int FINE_BITS = LOG2N / 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [LOG2N-1:0]     in_k,
    output logic                 out_valid,
    output logic signed [DW-1:0] w0_re,
    output logic signed [DW-1:0] w0_im,
    output logic signed [DW-1:0] w1_re,
    output logic signed [DW-1:0] w1_im,
    output logic signed [DW-1:0] w2_re,
    output logic signed [DW-1:0] w2_im,
    output logic signed [DW-1:0] w3_re,
    output logic signed [DW-1:0] w3_im
);
    localparam int     FB       = DW - 2;
    localparam int     BASE_LAT = 3;
    localparam int     DBL_LAT  = 2;
    localparam int     TRI_LAT  = 2;
    localparam int     LAT      = BASE_LAT + DBL_LAT + TRI_LAT;
    localparam longint ONE      = longint'(1) <<< FB;
    localparam longint ONE_SQ   = ONE * ONE;
    localparam longint MAG_TOL  = 32 * ONE;

    assign w0_re = DW'(ONE);
    assign w0_im = '0;

    logic signed [DW-1:0] b_c, b_s, a_c, a_s, d_c, d_s;
    logic [2*DW-1:0]      a_pk, w1_pk, w2_pk;
    logic [0:0]           vld_q;

    twr4_base_stage #(.DW(DW), .LOG2N(LOG2N), .FINE_BITS(FINE_BITS)) u_base (
        .clk(clk), .rst_n(rst_n), .k(in_k), .c_out(b_c), .s_out(b_s));

    // Base result aligned to the double-angle output; feeds the triple stage.
    twr4_delay #(.W(2*DW), .DEPTH(DBL_LAT)) u_dly_base (
        .clk(clk), .rst_n(rst_n), .d({b_c, b_s}), .q(a_pk));
    assign a_c = $signed(a_pk[2*DW-1:DW]);
    assign a_s = $signed(a_pk[DW-1:0]);

    twr4_double_stage #(.DW(DW)) u_dbl (
        .clk(clk), .rst_n(rst_n), .c_in(b_c), .s_in(b_s), .c2_out(d_c), .s2_out(d_s));

    twr4_triple_stage #(.DW(DW)) u_tri (
        .clk(clk), .rst_n(rst_n), .c_in(a_c), .s_in(a_s), .c2_in(d_c), .s2_in(d_s),
        .c3_out(w3_re), .s3_out(w3_im));

    twr4_delay #(.W(2*DW), .DEPTH(TRI_LAT)) u_dly_w1 (
        .clk(clk), .rst_n(rst_n), .d(a_pk), .q(w1_pk));
    twr4_delay #(.W(2*DW), .DEPTH(TRI_LAT)) u_dly_w2 (
        .clk(clk), .rst_n(rst_n), .d({d_c, d_s}), .q(w2_pk));
    twr4_delay #(.W(1), .DEPTH(LAT)) u_dly_vld (
        .clk(clk), .rst_n(rst_n), .d(in_valid), .q(vld_q));

    assign w1_re     = $signed(w1_pk[2*DW-1:DW]);
    assign w1_im     = $signed(w1_pk[DW-1:0]);
    assign w2_re     = $signed(w2_pk[2*DW-1:DW]);
    assign w2_im     = $signed(w2_pk[DW-1:0]);
    assign out_valid = vld_q[0];

    // Cycles since reset, saturating at LAT; lets checks avoid pre-reset history.
    int unsigned since_rst;
    always_ff @(posedge clk) begin
        if (!rst_n)              since_rst <= 0;
        else if (since_rst < LAT) since_rst <= since_rst + 1;
    end

    function automatic longint mag_dev(input logic signed [DW-1:0] re,
                                       input logic signed [DW-1:0] im);
        longint m;
        m = longint'(re) * longint'(re) + longint'(im) * longint'(im) - ONE_SQ;
        return (m < 0) ? -m : m;
    endfunction

    assert_valid_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == LAT) |-> (out_valid == $past(in_valid, LAT)));

    assert_reset_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < LAT) |-> !out_valid);

    assert_unit_mag_w1_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (mag_dev(w1_re, w1_im) <= MAG_TOL));

    assert_unit_mag_w3_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (mag_dev(w3_re, w3_im) <= MAG_TOL));
endmodule

// File: tb/twr4_recursive_gen_tb_top.sv
module twr4_recursive_gen_tb_top;
    localparam int     DW        = 16;
    localparam int     LOG2N     = 8;
    localparam int     FINE_BITS = 4;
    localparam int     N         = 1 << LOG2N;
    localparam int     NF        = 1 << FINE_BITS;
    localparam int     FB        = DW - 2;
    localparam int     LAT       = 7;
    localparam longint ONE       = longint'(1) <<< FB;
    localparam real    TWO_PI    = 6.283185307179586;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic [LOG2N-1:0]     in_k = '0;
    logic                 out_valid;
    logic signed [DW-1:0] w0_re, w0_im, w1_re, w1_im, w2_re, w2_im, w3_re, w3_im;

    twr4_recursive_gen #(.DW(DW), .LOG2N(LOG2N), .FINE_BITS(FINE_BITS)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_k(in_k),
        .out_valid(out_valid), .w0_re(w0_re), .w0_im(w0_im),
        .w1_re(w1_re), .w1_im(w1_im), .w2_re(w2_re), .w2_im(w2_im),
        .w3_re(w3_re), .w3_im(w3_im));

    always #10ns clk = ~clk;

    int compared   = 0;
    int mismatched = 0;
    bit finished   = 0;

    typedef struct { bit v; int k; } ent_t;
    ent_t pend_q[$];

    function automatic longint rnd(input longint x);
        longint r;
        longint hi;
        r  = (x + (longint'(1) <<< (FB - 1))) >>> FB;
        hi = (longint'(1) <<< (DW - 1)) - 1;
        if (r > hi) r = hi;
        if (r < -hi - 1) r = -hi - 1;
        return r;
    endfunction

    function automatic longint tabv(input int j, input bit want_sin);
        real th;
        real x;
        th = TWO_PI * real'(j) / real'(N);
        x  = want_sin ? -$sin(th) : $cos(th);
        return longint'($rtoi($floor(x * real'(ONE) + 0.5)));
    endfunction

    task automatic check(input string req, input string what, input longint act, input longint exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_near(input string req, input string what, input longint act, input real ideal);
        longint e;
        e = longint'($rtoi($floor(ideal * real'(ONE) + 0.5)));
        compared++;
        if (act > e + 8 || act < e - 8) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d (+/-8)", req, what, act, e);
        end
    endtask

    task automatic compare(input ent_t e);
        longint cc, cs, fc, fs, c1, s1, c2, s2, c3, s3;
        real th;
        check("R7", "w0_re", longint'(w0_re), ONE);
        check("R7", "w0_im", longint'(w0_im), 0);
        check(e.v ? "R5" : "R10", "out_valid", longint'(out_valid), longint'(e.v));
        if (e.v) begin
            cc = tabv((e.k >> FINE_BITS) * NF, 1'b0);
            cs = tabv((e.k >> FINE_BITS) * NF, 1'b1);
            fc = tabv(e.k % NF, 1'b0);
            fs = tabv(e.k % NF, 1'b1);
            c1 = rnd(cc * fc - cs * fs);
            s1 = rnd(cs * fc + cc * fs);
            c2 = rnd(2 * c1 * c1 - ONE * ONE);
            s2 = rnd(2 * s1 * c1);
            c3 = rnd(2 * c1 * c2 - c1 * ONE);
            s3 = rnd(2 * c1 * s2 - s1 * ONE);
            check("R1", "w1_re", longint'(w1_re), c1);
            check("R1", "w1_im", longint'(w1_im), s1);
            check("R2", "w2_re", longint'(w2_re), c2);
            check("R2", "w2_im", longint'(w2_im), s2);
            check("R3", "w3_re", longint'(w3_re), c3);
            check("R3", "w3_im", longint'(w3_im), s3);
            th = TWO_PI * real'(e.k) / real'(N);
            check_near("R9", "w1_re", longint'(w1_re), $cos(th));
            check_near("R9", "w2_im", longint'(w2_im), -$sin(2.0 * th));
            check_near("R9", "w3_re", longint'(w3_re), $cos(3.0 * th));
            check_near("R9", "w3_im", longint'(w3_im), -$sin(3.0 * th));
        end
    endtask

    // One clock: compare the entry from LAT cycles ago, then drive the next.
    task automatic cycle(input bit v, input int k);
        ent_t e;
        ent_t n;
        e = pend_q.pop_front();
        compare(e);
        n.v = v;
        n.k = k;
        pend_q.push_back(n);
        in_valid = v;
        in_k     = LOG2N'(k);
        @(negedge clk);
    endtask

    task automatic refill();
        ent_t z;
        z.v = 1'b0;
        z.k = 0;
        pend_q.delete();
        for (int i = 0; i < LAT; i++) pend_q.push_back(z);
    endtask

    task automatic reset_phase(input int cycles);
        rst_n    = 1'b0;
        in_valid = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            check("R8", "out_valid in reset", longint'(out_valid), 0);
            check("R8", "w1_re in reset", longint'(w1_re), 0);
            check("R8", "w3_im in reset", longint'(w3_im), 0);
        end
        rst_n = 1'b1;
        refill();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        #(20ns * 150000);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int lfsr;
        @(negedge clk);
        reset_phase(4);

        // R6: full sweep back to back.
        for (int k = 0; k < N; k++) cycle(1'b1, k);
        // R10: alternating bubbles.
        for (int i = 0; i < 64; i++) cycle(i % 2 == 0, (i * 37) % N);
        // R1: quadrant points, table seams and the last index.
        cycle(1'b1, 0);
        cycle(1'b1, N / 4);
        cycle(1'b1, N / 2);
        cycle(1'b1, 3 * N / 4);
        cycle(1'b1, N - 1);
        cycle(1'b1, NF);
        cycle(1'b1, NF - 1);
        cycle(1'b0, 5);
        cycle(1'b1, 2 * NF + 1);
        // Pseudo-random index and valid pattern.
        lfsr = 16'hACE1;
        for (int i = 0; i < 300; i++) begin
            lfsr = {16'(lfsr) >> 1} ^ ((lfsr & 1) != 0 ? 16'hB400 : 16'h0);
            cycle(lfsr[3] | lfsr[7], lfsr % N);
        end
        // R8: reset while results are in flight.
        for (int k = 10; k < 14; k++) cycle(1'b1, k);
        reset_phase(2);
        for (int i = 0; i < LAT; i++) cycle(1'b0, 0);
        for (int k = 100; k < 110; k++) cycle(1'b1, k);
        for (int i = 0; i < LAT + 2; i++) cycle(1'b0, 0);
        finish_run();
    end
endmodule